// File: doc/BRIEF.md
# Chip-Select Signalling Reset Detector

This block watches three serial-memory interface pins (the active-low chip select, the serial clock and data lane 0) for the in-band reset sequence that a host can send without a dedicated reset pin. The sequence is a train of four chip-select low pulses with the serial clock held at a steady level. The level of lane 0 at each chip-select fall must alternate from pulse to pulse, and lane 0 must stay low for the rest of each low pulse. When the sequence is recognised, the block emits a one-cycle request toward the reset controller.

The pins are asynchronous to the system clock. They pass through a synchroniser whose depth is a parameter, and the sequence is then judged on system-clock cycles. Each chip-select low and high interval must last a minimum number of system clocks. Normal command traffic always toggles the serial clock, so it can never be taken for the sequence. The block has no notion of single, dual or quad lane operation, so it behaves the same in every interface mode.

Top module: `cs_reset_detect`

## Requirements
- R1: After reset, `resetReq` is low and stays low while the chip select stays high.
- R2: Four chip-select low pulses that are separated by high intervals, that alternate the lane-0 level sampled at each fall, and during which the serial clock does not change, produce exactly one `resetReq` pulse that is one cycle wide. This pulse is registered on the SYNC_STAGES+1-th rising clock edge after the final chip-select rise is presented at the pins.
- R3: The first pulse may sample lane 0 either high or low, so the level sequences 1,0,1,0 and 0,1,0,1 are both accepted.
- R4: Any change of the synchronised serial clock discards all progress. A steady serial-clock level, high or low, is accepted.
- R5: A fall whose sampled lane-0 level equals the level at the previous fall breaks the alternation. That pulse then becomes pulse one of a new attempt, so 1,1,0,1,0 yields one request and 1,0,0,1 yields none.
- R6: Lane 0 seen high on any cycle after the fall cycle of a low pulse, up to and including the cycle of its rise, discards all progress.
- R7: A chip-select low interval shorter than MIN_CYCLES system clocks discards all progress. An interval of exactly MIN_CYCLES is accepted.
- R8: A fall that ends a chip-select high interval shorter than MIN_CYCLES clocks does not count and discards all progress. This also applies to the first pulse.
- R9: Fewer than four valid pulses produce no request. After a request the detector is rearmed at once, so eight valid alternating pulses produce two requests.
- R10: Ordinary transfers, where the serial clock toggles while chip select is low, never produce a request, and a valid sequence that follows them is still recognised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select from the pins, active low, asynchronous |
| sck | input | 1 | Serial clock from the pins, asynchronous |
| io0 | input | 1 | Data lane 0 from the pins, asynchronous |
| resetReq | output | 1 | One-cycle reset request strobe |

## Verification
The assertions assume that the pins settle between system-clock edges, so the synchronised copies of chip select, serial clock and lane 0 move together on the same cycle. They also assume that each chip-select level the detector judges lasts at least one system clock. The stimulus drives every pin on the falling clock edge and holds every level for a whole number of clock periods. Every low pulse is at least three cycles long, so that the mid-pulse lane-0 glitch and the serial-clock disturbance both fall strictly inside the pulse. Randomised pulse trains mix short intervals, broken alternation, serial-clock edges and lane-0 glitches, and a pulse-level model in the bench predicts the number of requests each train should produce.

// File: rtl/csrst_pkg.sv
package csrst_pkg;

  // Events seen by the datapath on the synchronised pins
  typedef struct packed {
    logic csFall;      // chip select went low this cycle
    logic csRise;      // chip select went high this cycle
    logic sckEdge;     // serial clock changed level this cycle
    logic ioHighLow;   // lane 0 high while a low pulse is in progress
    logic longEnough;  // the interval that just ended met the minimum
    logic levelFlips;  // lane 0 now differs from the last captured level
  } dpEvents_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureLvl;  // store lane 0 as the reference level
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } seqState_t;

endpackage

// File: rtl/csrst_datapath.sv
module csrst_datapath
  import csrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic        io0,
  input  ctlStrobes_t strobes,
  output dpEvents_t   events
);

  localparam int CNT_W = $clog2(MIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CYCLES);
  localparam logic [2:0] PIN_IDLE = 3'b100;  // {cs, sck, io0}

  logic [SYNC_STAGES-1:0][2:0] syncSh;
  logic [2:0] syncPins;

  // Synchroniser depth picks the shift variant
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncSh <= PIN_IDLE;
        else       syncSh <= {csN, sck, io0};
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncSh <= {SYNC_STAGES{PIN_IDLE}};
        else       syncSh <= {syncSh[SYNC_STAGES-2:0], {csN, sck, io0}};
      end
    end
  endgenerate

  assign syncPins = syncSh[SYNC_STAGES-1];

  logic syncCs, syncSck, syncIo;
  assign syncCs  = syncPins[2];
  assign syncSck = syncPins[1];
  assign syncIo  = syncPins[0];

  logic prevCs, prevSck, lastLvl;
  logic [CNT_W-1:0] intervalCnt;
  logic csEdge;

  assign csEdge = prevCs ^ syncCs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs      <= 1'b1;
      prevSck     <= 1'b0;
      lastLvl     <= 1'b0;
      intervalCnt <= '0;
    end else begin
      prevCs  <= syncCs;
      prevSck <= syncSck;
      if (strobes.captureLvl) lastLvl <= syncIo;
      if (csEdge)                      intervalCnt <= CNT_W'(1);
      else if (intervalCnt != CNT_MAX) intervalCnt <= intervalCnt + CNT_W'(1);
    end
  end

  always_comb begin
    events.csFall     = prevCs & ~syncCs;
    events.csRise     = ~prevCs & syncCs;
    events.sckEdge    = prevSck ^ syncSck;
    events.ioHighLow  = ~prevCs & syncIo;
    events.longEnough = (intervalCnt == CNT_MAX);
    events.levelFlips = syncIo ^ lastLvl;
  end

  // R7
  interval_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    intervalCnt <= CNT_MAX);

  // R8
  edge_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    csEdge |=> !events.longEnough || (MIN_CYCLES <= 1));

endmodule

// File: rtl/csrst_control.sv
module csrst_control
  import csrst_pkg::*;
#(
  parameter int PULSES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpEvents_t   events,
  output ctlStrobes_t strobes,
  output logic        resetReq
);

  localparam int CNT_W = $clog2(PULSES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES);

  seqState_t st, stNext;
  logic [CNT_W-1:0] pulseCnt, cntNext;
  logic fireNext;

  always_comb begin
    stNext             = st;
    cntNext            = pulseCnt;
    fireNext           = 1'b0;
    strobes.captureLvl = 1'b0;
    if (events.sckEdge) begin
      stNext  = ST_IDLE;
      cntNext = '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (events.csFall && events.longEnough) begin
            stNext             = ST_LOW;
            cntNext            = CNT_W'(1);
            strobes.captureLvl = 1'b1;
          end
        end
        ST_LOW: begin
          if (events.ioHighLow || (events.csRise && !events.longEnough)) begin
            stNext  = ST_IDLE;
            cntNext = '0;
          end else if (events.csRise) begin
            if (pulseCnt == LAST) begin
              fireNext = 1'b1;
              stNext   = ST_IDLE;
              cntNext  = '0;
            end else begin
              stNext = ST_HIGH;
            end
          end
        end
        ST_HIGH: begin
          if (events.csFall) begin
            if (!events.longEnough) begin
              stNext  = ST_IDLE;
              cntNext = '0;
            end else begin
              stNext             = ST_LOW;
              strobes.captureLvl = 1'b1;
              cntNext = events.levelFlips ? pulseCnt + CNT_W'(1) : CNT_W'(1);
            end
          end
        end
        default: begin
          stNext  = ST_IDLE;
          cntNext = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      pulseCnt <= '0;
      resetReq <= 1'b0;
    end else begin
      st       <= stNext;
      pulseCnt <= cntNext;
      resetReq <= fireNext;
    end
  end

  // R2
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R2
  fire_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> ($past(events.csRise) && $past(pulseCnt) == LAST));

  // R4
  sck_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    events.sckEdge |=> (pulseCnt == '0 && !resetReq));

  // R9
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= LAST);

  // R7
  short_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_LOW && events.csRise && !events.longEnough) |=> !resetReq);

endmodule

// File: rtl/cs_reset_detect.sv
module cs_reset_detect
  import csrst_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_CYCLES  = 4,
  parameter int PULSES      = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic io0,
  output logic resetReq
);

  dpEvents_t   dpEvents;
  ctlStrobes_t ctlStrobes;

  csrst_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_CYCLES (MIN_CYCLES)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .sck    (sck),
    .io0    (io0),
    .strobes(ctlStrobes),
    .events (dpEvents)
  );

  csrst_control #(
    .PULSES(PULSES)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .events  (dpEvents),
    .strobes (ctlStrobes),
    .resetReq(resetReq)
  );

endmodule

// File: tb/tb_cs_reset_detect.sv
module tb_cs_reset_detect;

  localparam int SYNC = 2;
  localparam int MINC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic io0 = 1'b0;
  logic resetReq;

  always #4 clk = ~clk;  // 125 MHz

  cs_reset_detect #(.SYNC_STAGES(SYNC), .MIN_CYCLES(MINC), .PULSES(4)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .io0(io0), .resetReq(resetReq)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int reqCount = 0;
  int lastReqCyc = 0;
  int lastRiseCyc = 0;
  int runLen = 0;
  int maxRun = 0;

  // pulse-level model state
  int  mCnt = 0;
  bit  mLast = 1'b0;
  bit  mHighOk = 1'b0;
  int  mReq = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (resetReq) begin
      reqCount   <= reqCount + 1;
      lastReqCyc <= cyc;
      runLen     <= runLen + 1;
      if (runLen + 1 > maxRun) maxRun <= runLen + 1;
    end else begin
      runLen <= 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Apply one model step for a pulse
  task automatic modelPulse(input bit lvl, input int lowLen, input int highLen,
                            input bit sckHit, input bit ioHit);
    if (!mHighOk) mCnt = 0;
    else if (mCnt == 0) begin mCnt = 1; mLast = lvl; end
    else begin
      mCnt  = (lvl != mLast) ? mCnt + 1 : 1;
      mLast = lvl;
    end
    if (sckHit || ioHit) mCnt = 0;
    if (mCnt > 0) begin
      if (lowLen < MINC) mCnt = 0;
      else if (mCnt == 4) begin mReq++; mCnt = 0; end
    end
    mHighOk = (highLen >= MINC);
  endtask

  // One chip-select low pulse followed by a high interval (lowLen >= 3)
  task automatic pulse(input bit lvl, input int lowLen, input int highLen,
                       input bit sckHit, input bit ioHit);
    csN = 1'b0; io0 = lvl;
    @(negedge clk);
    io0 = ioHit;
    if (sckHit) sck = ~sck;
    @(negedge clk);
    io0 = 1'b0;
    idle(lowLen - 2);
    csN = 1'b1;
    lastRiseCyc = cyc;
    @(negedge clk);
    io0 = 1'($urandom);
    idle(highLen - 1);
    modelPulse(lvl, lowLen, highLen, sckHit, ioHit);
  endtask

  // Two serial-clock edges with chip select high discard any progress
  task automatic clearPattern();
    sck = ~sck;
    idle(2);
    sck = ~sck;
    idle(MINC + 4);
    mCnt = 0;
    mHighOk = 1'b1;
  endtask

  task automatic traffic(input int toggles);
    csN = 1'b0;
    for (int i = 0; i < toggles; i++) begin
      @(negedge clk);
      sck = ~sck;
      io0 = 1'($urandom);
    end
    idle(2);
    csN = 1'b1;
    idle(MINC + 2);
    mCnt = 0;
    mHighOk = 1'b1;
  endtask

  task automatic seq4(input bit first);
    pulse(first, 6, 6, 1'b0, 1'b0);
    pulse(~first, 6, 6, 1'b0, 1'b0);
    pulse(first, 6, 6, 1'b0, 1'b0);
    pulse(~first, 6, 6, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int base;
    void'($urandom(32'd1234));
    idle(3);
    rstN = 1'b1;
    idle(20);
    // R1
    check("R1 no request after reset", reqCount, 0);
    check("R1 output low after reset", int'(resetReq), 0);

    // R2: valid 1010 sequence, count, latency and width
    clearPattern();
    base = reqCount;
    seq4(1'b1);
    idle(6);
    check("R2 one request for 1010", reqCount - base, 1);
    check("R2 latency from final rise", lastReqCyc - lastRiseCyc, SYNC + 1);
    check("R2 request one cycle wide", maxRun, 1);

    // R3: sequence starting low
    clearPattern();
    base = reqCount;
    seq4(1'b0);
    idle(6);
    check("R3 one request for 0101", reqCount - base, 1);

    // R7: exactly minimum intervals accepted
    clearPattern();
    base = reqCount;
    pulse(1'b1, MINC, MINC, 1'b0, 1'b0);
    pulse(1'b0, MINC, MINC, 1'b0, 1'b0);
    pulse(1'b1, MINC, MINC, 1'b0, 1'b0);
    pulse(1'b0, MINC, MINC + 4, 1'b0, 1'b0);
    idle(4);
    check("R7 minimum intervals accepted", reqCount - base, 1);

    // R7: last low interval one short
    clearPattern();
    base = reqCount;
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 6, 1'b0, 1'b0);
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, MINC - 1, 8, 1'b0, 1'b0);
    check("R7 short low interval rejected", reqCount - base, 0);

    // R8: short high interval before the third pulse
    clearPattern();
    base = reqCount;
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, MINC - 1, 1'b0, 1'b0);
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 8, 1'b0, 1'b0);
    check("R8 short high interval rejected", reqCount - base, 0);

    // R4: serial clock edge in pulse three
    clearPattern();
    base = reqCount;
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 6, 1'b0, 1'b0);
    pulse(1'b1, 6, 6, 1'b1, 1'b0);
    pulse(1'b0, 6, 8, 1'b0, 1'b0);
    check("R4 serial clock edge discards", reqCount - base, 0);

    // R4: serial clock steady high
    sck = 1'b1;
    idle(4);
    clearPattern();
    base = reqCount;
    seq4(1'b1);
    idle(6);
    check("R4 steady high serial clock accepted", reqCount - base, 1);
    sck = 1'b0;
    idle(4);

    // R6: lane 0 glitch inside pulse two
    clearPattern();
    base = reqCount;
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 6, 1'b0, 1'b1);
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 8, 1'b0, 1'b0);
    check("R6 lane 0 high during low discards", reqCount - base, 0);

    // R5: broken alternation restarts
    clearPattern();
    base = reqCount;
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 6, 1'b0, 1'b0);
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 8, 1'b0, 1'b0);
    check("R5 restart after repeated level", reqCount - base, 1);
    clearPattern();
    base = reqCount;
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 6, 1'b0, 1'b0);
    pulse(1'b1, 6, 8, 1'b0, 1'b0);
    check("R5 broken alternation no request", reqCount - base, 0);

    // R9: three pulses, then eight pulses
    clearPattern();
    base = reqCount;
    pulse(1'b1, 6, 6, 1'b0, 1'b0);
    pulse(1'b0, 6, 6, 1'b0, 1'b0);
    pulse(1'b1, 6, 10, 1'b0, 1'b0);
    check("R9 three pulses no request", reqCount - base, 0);
    clearPattern();
    base = reqCount;
    seq4(1'b0);
    seq4(1'b0);
    idle(6);
    check("R9 eight pulses give two requests", reqCount - base, 2);

    // R10: ordinary traffic, then a valid sequence
    clearPattern();
    base = reqCount;
    traffic(16);
    traffic(8);
    check("R10 traffic gives no request", reqCount - base, 0);
    seq4(1'b1);
    idle(6);
    check("R10 sequence after traffic accepted", reqCount - base, 1);

    // Random pulse trains checked against the model
    for (int b = 0; b < 8; b++) begin
      bit lvl;
      clearPattern();
      base = reqCount;
      mReq = 0;
      lvl = 1'($urandom);
      for (int p = 0; p < 30; p++) begin
        int lo, hi;
        lvl = ($urandom % 8 == 0) ? lvl : ~lvl;
        lo = ($urandom % 8 == 0) ? MINC - 1 : MINC + int'($urandom % 3);
        hi = ($urandom % 8 == 0) ? MINC - 1 : MINC + int'($urandom % 3);
        pulse(lvl, lo, hi, ($urandom % 16 == 0), ($urandom % 16 == 0));
      end
      idle(MINC + 6);
      // R2 R5 R6 R7 R8 random mix
      check("R2 random train request count", reqCount - base, mReq);
    end
    check("R2 request never wider than one cycle", maxRun, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule